// File: doc/BRIEF.md
# Transactional Read/Write Set Tracker

This block keeps the per-line bookkeeping a core needs to run a memory transaction speculatively. While a transaction is open it records, for every cache line the core loads or stores, a read mark and a write mark, keyed by the physical line address. It compares every incoming coherence snoop against those marks. A conflict exists only when at least one of the two sides writes. When a conflict is found, the block aborts the transaction. It also aborts when a written line must leave the cache, or when software asks for an abort. An abort pulses a command that tells the data array to throw away every line written inside the transaction. A commit simply drops all marks in one cycle, so the buffered writes become visible together without any exchange with other cores.

Lines are tracked in a direct-mapped table indexed by line-address bits [11:6], with the remaining upper bits held as a tag. A line that holds only a read mark may still leave the table, either by eviction or because another line needs its slot. In that case its address is not forgotten: it is folded into a two-hash bit filter, and a later remote write that hits both of its bits counts as a conflict. The data storage and the coherence engine are outside this block.

The three event inputs (local access, snoop, eviction) are qualified by their own valid bit and are never back-pressured. The block accepts one event of each kind in every cycle. Commands and results are plain level or pulse pins.

Top module: `txn_line_tracker`

## Requirements
- R1: After reset `in_txn`, `abort_o` and `inval_written` are 0 and `abort_cause` is 2'b00. While no transaction is open, snoops, evictions, accesses and `txn_abort_req` cause no abort.
- R2: `txn_begin` while idle raises `in_txn` one cycle later. `txn_begin` while a transaction is open is ignored, and the marks already collected are kept.
- R3: A snoop read (`snp_write`=0) to a line that carries only a read mark is not a conflict.
- R4: A snoop write to a line with a read or write mark, or a snoop read to a line with a write mark, aborts with cause 2'b01.
- R5: Evicting a line with a write mark aborts with cause 2'b10. A local access whose table slot holds a different line carrying a write mark also aborts with cause 2'b10.
- R6: A read-only line that leaves the table, by eviction or by being displaced by another line, stays tracked. A later snoop write to it aborts with cause 2'b01, and a snoop read to it does not.
- R7: `txn_abort_req` during a transaction aborts with cause 2'b11.
- R8: When several abort reasons arrive in the same cycle, the cause reported is 2'b11 ahead of 2'b01 ahead of 2'b10.
- R9: An abort pulses `abort_o` and `inval_written` for exactly one cycle, the cycle after the triggering event. `in_txn` is low in that same cycle, and all marks and the filter are cleared. `abort_cause` holds until the next accepted begin.
- R10: `txn_commit` during a transaction lowers `in_txn` one cycle later without an abort and clears all marks and the filter, so the same lines no longer conflict in the next transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txn_begin | input | 1 | Open a transaction |
| txn_commit | input | 1 | Commit the open transaction |
| txn_abort_req | input | 1 | Explicit abort request |
| acc_valid | input | 1 | Local load/store event valid |
| acc_write | input | 1 | 1 = store, 0 = load |
| acc_addr | input | ADDR_W | Physical address of the local access |
| snp_valid | input | 1 | Incoming snoop valid |
| snp_write | input | 1 | 1 = write intent, 0 = read intent |
| snp_addr | input | ADDR_W | Physical address of the snoop |
| evc_valid | input | 1 | Eviction notice valid |
| evc_addr | input | ADDR_W | Physical address of the evicted line |
| in_txn | output | 1 | A transaction is open |
| abort_o | output | 1 | One-cycle abort pulse |
| abort_cause | output | 2 | 01 snoop conflict, 10 written-line loss, 11 explicit |
| inval_written | output | 1 | One-cycle command to discard all transactionally written lines |

## Verification
Every result is registered once, so an event presented in one cycle shows on `abort_o`, `abort_cause`, `inval_written` and `in_txn` just after the next rising edge. Begin and commit take effect on `in_txn` with the same single-cycle delay. The driver applies each event on a falling edge and enqueues the outputs expected after the following rising edge. The monitor dequeues one entry a moment after that rising edge and compares it, so every comparison falls exactly one cycle after its stimulus. Conflicts and the later checks that confirm marks were cleared are driven as separate cycles, so each expected entry belongs to exactly one event.

// File: rtl/txn_trk_pkg.sv
package txn_trk_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE     = 2'b00,
    CAUSE_SNOOP    = 2'b01,
    CAUSE_WR_LOSS  = 2'b10,
    CAUSE_EXPLICIT = 2'b11
  } abort_cause_e;
endpackage

// File: rtl/txn_evict_filter.sv
module txn_evict_filter #(
  parameter int LINE_W    = 26,
  parameter int FILT_BITS = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              ins0_v,
  input  logic [LINE_W-1:0] ins0_line,
  input  logic              ins1_v,
  input  logic [LINE_W-1:0] ins1_line,
  input  logic [LINE_W-1:0] qry_line,
  output logic              qry_hit
);
  localparam int HW = $clog2(FILT_BITS);

  logic [FILT_BITS-1:0] bits_q;

  function automatic logic [HW-1:0] hash_a(input logic [LINE_W-1:0] l);
    logic [HW-1:0] h;
    h = '0;
    for (int i = 0; i < LINE_W; i++) h[i % HW] = h[i % HW] ^ l[i];
    return h;
  endfunction

  function automatic logic [HW-1:0] hash_b(input logic [LINE_W-1:0] l);
    logic [HW-1:0] h;
    h = '1;
    for (int i = 0; i < LINE_W; i++) h[(i + i / HW + 1) % HW] = h[(i + i / HW + 1) % HW] ^ l[i];
    return h;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      bits_q <= '0;
    end else begin
      if (ins0_v) begin
        bits_q[hash_a(ins0_line)] <= 1'b1;
        bits_q[hash_b(ins0_line)] <= 1'b1;
      end
      if (ins1_v) begin
        bits_q[hash_a(ins1_line)] <= 1'b1;
        bits_q[hash_b(ins1_line)] <= 1'b1;
      end
    end
  end

  assign qry_hit = bits_q[hash_a(qry_line)] & bits_q[hash_b(qry_line)];
endmodule

// File: rtl/txn_line_table.sv
module txn_line_table #(
  parameter int LINE_W = 26,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_all,
  input  logic              acc_v,
  input  logic              acc_wr,
  input  logic [LINE_W-1:0] acc_line,
  input  logic              evc_v,
  input  logic [LINE_W-1:0] evc_line,
  input  logic [LINE_W-1:0] snp_line,
  output logic              snp_rd_hit,
  output logic              snp_wr_hit,
  output logic              evc_rd_hit,
  output logic              evc_wr_hit,
  output logic              alias_v,
  output logic              alias_wr,
  output logic [LINE_W-1:0] alias_line
);
  localparam int N     = 1 << IDX_W;
  localparam int TAG_W = LINE_W - IDX_W;

  logic [N-1:0]     rd_q, wr_q;
  logic [TAG_W-1:0] tag_q [N];

  logic [IDX_W-1:0] acc_idx, evc_idx, snp_idx;
  logic [TAG_W-1:0] acc_tag, evc_tag, snp_tag;
  logic             acc_occ, acc_match, snp_match, evc_match;

  assign acc_idx = acc_line[IDX_W-1:0];
  assign evc_idx = evc_line[IDX_W-1:0];
  assign snp_idx = snp_line[IDX_W-1:0];
  assign acc_tag = acc_line[LINE_W-1:IDX_W];
  assign evc_tag = evc_line[LINE_W-1:IDX_W];
  assign snp_tag = snp_line[LINE_W-1:IDX_W];

  assign acc_occ   = rd_q[acc_idx] | wr_q[acc_idx];
  assign acc_match = acc_occ && (tag_q[acc_idx] == acc_tag);
  assign snp_match = (rd_q[snp_idx] | wr_q[snp_idx]) && (tag_q[snp_idx] == snp_tag);
  assign evc_match = (rd_q[evc_idx] | wr_q[evc_idx]) && (tag_q[evc_idx] == evc_tag);

  assign snp_rd_hit = snp_match & rd_q[snp_idx];
  assign snp_wr_hit = snp_match & wr_q[snp_idx];
  assign evc_rd_hit = evc_match & rd_q[evc_idx];
  assign evc_wr_hit = evc_match & wr_q[evc_idx];
  assign alias_v    = acc_v & acc_occ & ~acc_match;
  assign alias_wr   = wr_q[acc_idx];
  assign alias_line = {tag_q[acc_idx], acc_idx};

  always_ff @(posedge clk) begin
    if (!rst_n || clr_all) begin
      rd_q <= '0;
      wr_q <= '0;
    end else begin
      if (evc_v && evc_match) begin
        rd_q[evc_idx] <= 1'b0;
        wr_q[evc_idx] <= 1'b0;
      end
      if (acc_v) begin
        if (acc_match && !(evc_v && evc_match && evc_idx == acc_idx)) begin
          rd_q[acc_idx] <= rd_q[acc_idx] | ~acc_wr;
          wr_q[acc_idx] <= wr_q[acc_idx] | acc_wr;
        end else begin
          rd_q[acc_idx] <= ~acc_wr;
          wr_q[acc_idx] <= acc_wr;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (acc_v) tag_q[acc_idx] <= acc_tag;
  end
endmodule

// File: rtl/txn_line_tracker.sv
module txn_line_tracker
  import txn_trk_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LINE_OFF  = 6,
  parameter int IDX_W     = 6,
  parameter int FILT_BITS = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txn_begin,
  input  logic              txn_commit,
  input  logic              txn_abort_req,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              snp_valid,
  input  logic              snp_write,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic              evc_valid,
  input  logic [ADDR_W-1:0] evc_addr,
  output logic              in_txn,
  output logic              abort_o,
  output logic [1:0]        abort_cause,
  output logic              inval_written
);
  localparam int LINE_W = ADDR_W - LINE_OFF;

  logic              active_q, abort_q, inval_q;
  abort_cause_e      cause_q, cause_d;
  logic              snp_rd_hit, snp_wr_hit, evc_rd_hit, evc_wr_hit;
  logic              alias_v, alias_wr, filt_hit;
  logic [LINE_W-1:0] alias_line;
  logic              tbl_acc_v, tbl_evc_v;
  logic              c_explicit, c_snoop, c_loss, abort_now, commit_now, clr_all;

  assign tbl_acc_v = active_q & acc_valid;
  assign tbl_evc_v = active_q & evc_valid;

  txn_line_table #(.LINE_W(LINE_W), .IDX_W(IDX_W)) u_table (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_all    (clr_all),
    .acc_v      (tbl_acc_v),
    .acc_wr     (acc_write),
    .acc_line   (acc_addr[ADDR_W-1:LINE_OFF]),
    .evc_v      (tbl_evc_v),
    .evc_line   (evc_addr[ADDR_W-1:LINE_OFF]),
    .snp_line   (snp_addr[ADDR_W-1:LINE_OFF]),
    .snp_rd_hit (snp_rd_hit),
    .snp_wr_hit (snp_wr_hit),
    .evc_rd_hit (evc_rd_hit),
    .evc_wr_hit (evc_wr_hit),
    .alias_v    (alias_v),
    .alias_wr   (alias_wr),
    .alias_line (alias_line)
  );

  txn_evict_filter #(.LINE_W(LINE_W), .FILT_BITS(FILT_BITS)) u_filter (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr_all),
    .ins0_v    (tbl_evc_v & evc_rd_hit & ~evc_wr_hit),
    .ins0_line (evc_addr[ADDR_W-1:LINE_OFF]),
    .ins1_v    (alias_v & ~alias_wr),
    .ins1_line (alias_line),
    .qry_line  (snp_addr[ADDR_W-1:LINE_OFF]),
    .qry_hit   (filt_hit)
  );

  assign c_explicit = active_q & txn_abort_req;
  assign c_snoop    = active_q & snp_valid &
                      (snp_write ? (snp_rd_hit | snp_wr_hit | filt_hit) : snp_wr_hit);
  assign c_loss     = (tbl_evc_v & evc_wr_hit) | (alias_v & alias_wr);
  assign abort_now  = c_explicit | c_snoop | c_loss;
  assign commit_now = active_q & txn_commit & ~abort_now;
  assign clr_all    = abort_now | commit_now;

  always_comb begin
    if (c_explicit)   cause_d = CAUSE_EXPLICIT;
    else if (c_snoop) cause_d = CAUSE_SNOOP;
    else              cause_d = CAUSE_WR_LOSS;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      abort_q  <= 1'b0;
      inval_q  <= 1'b0;
      cause_q  <= CAUSE_NONE;
    end else begin
      abort_q <= abort_now;
      inval_q <= abort_now;
      if (abort_now) begin
        active_q <= 1'b0;
        cause_q  <= cause_d;
      end else if (commit_now) begin
        active_q <= 1'b0;
      end else if (!active_q && txn_begin) begin
        active_q <= 1'b1;
        cause_q  <= CAUSE_NONE;
      end
    end
  end

  assign in_txn        = active_q;
  assign abort_o       = abort_q;
  assign abort_cause   = cause_q;
  assign inval_written = inval_q;
endmodule

// File: rtl/txn_line_tracker_chk.sv
module txn_line_tracker_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              txn_begin,
  input logic              txn_commit,
  input logic              txn_abort_req,
  input logic              snp_valid,
  input logic              evc_valid,
  input logic              acc_valid,
  input logic              in_txn,
  input logic              abort_o,
  input logic [1:0]        abort_cause,
  input logic              inval_written
);
  AST_IDLE_NO_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    !in_txn |=> !abort_o) else $error("idle abort"); // R1
  AST_BEGIN_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_txn && txn_begin) |=> in_txn) else $error("begin"); // R2
  AST_EXPLICIT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_txn && txn_abort_req) |=> (abort_o && abort_cause == 2'b11)) else $error("explicit"); // R7
  AST_ABORT_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> (!in_txn && inval_written && abort_cause != 2'b00)) else $error("abort"); // R9
  AST_ABORT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |=> !abort_o) else $error("pulse"); // R9
  AST_COMMIT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_txn && txn_commit && !txn_abort_req && !snp_valid && !evc_valid && !acc_valid)
      |=> (!in_txn && !abort_o)) else $error("commit"); // R10
endmodule

bind txn_line_tracker txn_line_tracker_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .txn_begin(txn_begin), .txn_commit(txn_commit),
  .txn_abort_req(txn_abort_req), .snp_valid(snp_valid), .evc_valid(evc_valid),
  .acc_valid(acc_valid), .in_txn(in_txn), .abort_o(abort_o),
  .abort_cause(abort_cause), .inval_written(inval_written)
);

// File: tb/txn_line_tracker_tb.sv
module txn_line_tracker_tb;
  localparam int AW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic txn_begin = 0, txn_commit = 0, txn_abort_req = 0;
  logic acc_valid = 0, acc_write = 0, snp_valid = 0, snp_write = 0, evc_valid = 0;
  logic [AW-1:0] acc_addr = '0, snp_addr = '0, evc_addr = '0;
  logic in_txn, abort_o, inval_written;
  logic [1:0] abort_cause;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  typedef struct { logic ab; logic [1:0] cause; logic act; string req; } exp_t;
  exp_t sb_q[$];

  localparam logic [AW-1:0] LA = 32'h0000_1040; // index 1, tag 1
  localparam logic [AW-1:0] LB = 32'h0000_2040; // index 1, tag 2
  localparam logic [AW-1:0] LC = 32'h0000_3080; // index 2
  localparam logic [AW-1:0] LD = 32'h0000_5140; // index 5

  always #5 clk = ~clk;

  txn_line_tracker u_dut (
    .clk(clk), .rst_n(rst_n), .txn_begin(txn_begin), .txn_commit(txn_commit),
    .txn_abort_req(txn_abort_req), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .snp_valid(snp_valid), .snp_write(snp_write),
    .snp_addr(snp_addr), .evc_valid(evc_valid), .evc_addr(evc_addr),
    .in_txn(in_txn), .abort_o(abort_o), .abort_cause(abort_cause),
    .inval_written(inval_written)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor: one entry due just after each rising edge
  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      chk(e.req, "abort_o", abort_o, e.ab);
      chk(e.req, "inval_written", inval_written, e.ab);
      chk(e.req, "in_txn", in_txn, e.act);
      if (e.ab) chk(e.req, "abort_cause", abort_cause, e.cause);
    end
  end

  // kind: 0 none,1 begin,2 commit,3 abort_req,4 load,5 store,6 snoop rd,7 snoop wr,8 evict
  task automatic step(input int kind, input logic [AW-1:0] a, input logic ab,
                      input logic [1:0] cause, input logic act, input string req);
    exp_t e;
    @(negedge clk);
    txn_begin = (kind == 1); txn_commit = (kind == 2); txn_abort_req = (kind == 3);
    acc_valid = (kind == 4 || kind == 5); acc_write = (kind == 5); acc_addr = a;
    snp_valid = (kind == 6 || kind == 7); snp_write = (kind == 7); snp_addr = a;
    evc_valid = (kind == 8); evc_addr = a;
    e.ab = ab; e.cause = cause; e.act = act; e.req = req;
    sb_q.push_back(e);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "reset in_txn", in_txn, 0);
    chk("R1", "reset abort_o", abort_o, 0);
    chk("R1", "reset cause", abort_cause, 0);
    @(negedge clk); rst_n = 1'b1;
    step(7, LA, 0, 0, 0, "R1");   // snoop write while idle
    step(3, LA, 0, 0, 0, "R1");   // abort request while idle
    step(1, 0, 0, 0, 1, "R2");
    step(4, LA, 0, 0, 1, "R3");
    step(6, LA, 0, 0, 1, "R3");   // read vs read
    step(7, LA, 1, 2'b01, 0, "R4");
    step(0, 0, 0, 0, 0, "R9");    // pulse over
    step(1, 0, 0, 0, 1, "R2");
    step(5, LC, 0, 0, 1, "R4");
    step(6, LC, 1, 2'b01, 0, "R4");   // read vs written line
    step(1, 0, 0, 0, 1, "R10");
    step(4, LA, 0, 0, 1, "R10");
    step(7, LD, 0, 0, 1, "R4");   // untouched line
    step(2, 0, 0, 0, 0, "R10");
    step(7, LA, 0, 0, 0, "R10");
    step(1, 0, 0, 0, 1, "R10");
    step(7, LA, 0, 0, 1, "R10");  // marks gone after commit
    step(5, LC, 0, 0, 1, "R5");
    step(8, LC, 1, 2'b10, 0, "R5");
    step(1, 0, 0, 0, 1, "R6");
    step(4, LA, 0, 0, 1, "R6");
    step(8, LA, 0, 0, 1, "R6");
    step(6, LA, 0, 0, 1, "R6");
    step(7, LA, 1, 2'b01, 0, "R6");
    step(1, 0, 0, 0, 1, "R7");
    step(3, 0, 1, 2'b11, 0, "R7");
    step(1, 0, 0, 0, 1, "R5");
    step(5, LA, 0, 0, 1, "R5");
    step(4, LB, 1, 2'b10, 0, "R5");   // displaces written line
    step(1, 0, 0, 0, 1, "R6");
    step(4, LA, 0, 0, 1, "R6");
    step(4, LB, 0, 0, 1, "R6");       // displaces read line
    step(7, LA, 1, 2'b01, 0, "R6");
    step(1, 0, 0, 0, 1, "R2");
    step(4, LA, 0, 0, 1, "R2");
    step(1, 0, 0, 0, 1, "R2");        // nested begin ignored
    step(7, LA, 1, 2'b01, 0, "R2");
    step(1, 0, 0, 0, 1, "R8");
    step(5, LC, 0, 0, 1, "R8");
    // explicit + eviction of written line together
    @(negedge clk);
    txn_begin = 0; acc_valid = 0; txn_abort_req = 1; evc_valid = 1; evc_addr = LC;
    begin exp_t e; e.ab = 1; e.cause = 2'b11; e.act = 0; e.req = "R8"; sb_q.push_back(e); end
    step(1, 0, 0, 0, 1, "R8");
    step(5, LC, 0, 0, 1, "R8");
    // snoop conflict + eviction of written line together
    @(negedge clk);
    txn_begin = 0; acc_valid = 0; acc_write = 0; snp_valid = 1; snp_write = 1; snp_addr = LC;
    evc_valid = 1; evc_addr = LC;
    begin exp_t e; e.ab = 1; e.cause = 2'b01; e.act = 0; e.req = "R8"; sb_q.push_back(e); end
    step(0, 0, 0, 0, 0, "R9");
    @(negedge clk);
    #2;
    chk("R9", "cause held", abort_cause, 2'b01);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual running expected finished");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule